// File: doc/BRIEF.md
# Multi-standard audio serial transmitter

This block is a master-mode audio transmitter. It takes pairs of left and right sample words and drives three lines: a bit clock, a word-select line (or a frame-sync line in PCM framing), and a serial data line. The bit clock comes from the system clock through an enable-based divider. One bit period is `2*HALF_DIV` system clocks. A configuration port selects one of four framing standards, the sample length, the per-channel slot length, the idle level of the bit clock and, in PCM framing, a short or long frame sync. The configuration is captured only while the block is disabled. While it runs, the captured configuration stays frozen.

Samples enter through a valid/ready stream with a single holding slot. `s_ready` is high exactly when the slot is empty. A pair is accepted on any clock in which `s_valid` and `s_ready` are both high. A source that is held off simply keeps `s_valid` and its data steady until it sees `s_ready`. The holding slot is emptied at each frame start.

If the slot is empty at a frame start, the frame carries zeros and a sticky underrun flag is set. This flag is cleared by `underrun_clr`. Disabling the block stops the frame at once. Enabling it again starts a new frame from its first bit.

Top module: `audfmt_tx`

## Requirements
- R1: `s_ready` is high exactly when the holding slot is empty. A pair accepted on a clock edge fills the slot. At every frame-start edge the slot is moved into the frame and emptied. A pair that arrives on the same edge as a frame start that found the slot empty is kept for the next frame.
- R2: While disabled, `sck` rests at the captured polarity (0 = low, 1 = high). While running, each bit period lasts `2*HALF_DIV` clocks. The first `HALF_DIV` clocks of a period are at the idle level and the rest are at the opposite level. `sd` and `ws` change only at period starts.
- R3: The standard, sync style, polarity, data length and slot length are captured on every clock edge where `enable` is low. Changes made while `enable` is high have no effect on the outputs.
- R4: Standard code 00 (Philips) uses a frame of two slots. `ws` is 0 in the left slot and 1 in the right slot. Data goes MSB first and lags by one bit, so each word's MSB comes one bit after the `ws` change. The first bit after enable is 0.
- R5: Standard code 01 (left-aligned) places the MSB in the first bit of each slot, with `ws` as in R4. Bits of a slot after the data are 0. This also holds for the data bits under R4.
- R6: Standard code 10 (right-aligned) places the LSB in the last bit of each slot and drives the leading unused bits as 0, with `ws` as in R4.
- R7: Data length code 00 selects 16 bits, 01 selects 24 bits and 10 selects 32 bits. The sample sits in bits [N-1:0] of the 32-bit input word, and the bits above N are ignored.
- R8: Slot bit 0 selects a 16-bit slot and 1 selects a 32-bit slot. The bit applies only to 16-bit data; 24-bit and 32-bit data always use 32-bit slots.
- R9: Standard code 11 (PCM) uses a frame of one slot carrying the left word, and the right word is ignored. With sync style 0 (short), `ws` is high only in the last bit of each frame, just before the next MSB. The sync-style bit has no effect under the other standards.
- R10: PCM with sync style 1 (long) drives `ws` high for the first 13 bits of each frame, starting with the MSB.
- R11: Data length code 11 raises `cfg_err` and is treated as 16-bit. `cfg_err` follows the captured configuration.
- R12: A frame start with an empty holding slot sends zeros for the whole frame and sets `underrun`. `underrun` stays set until a clock with `underrun_clr` high. If a new underrun happens on that same clock, the flag stays set.
- R13: During reset, and from the first clock edge with `enable` low, `sd` and `ws` are 0. After reset, `s_ready` is 1 and `underrun` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the serializer; low captures configuration |
| cfg_std | input | 2 | Framing: 00 Philips, 01 left, 10 right, 11 PCM |
| cfg_sync_long | input | 1 | PCM sync style: 0 short, 1 long |
| cfg_cpol | input | 1 | Idle level of the bit clock |
| cfg_dlen | input | 2 | Data length: 00 16, 01 24, 10 32, 11 illegal |
| cfg_slot32 | input | 1 | Slot length for 16-bit data: 0 16, 1 32 |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding slot empty, pair will be accepted |
| s_left | input | 32 | Left sample, right-justified |
| s_right | input | 32 | Right sample, right-justified |
| underrun_clr | input | 1 | Clear the underrun flag |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select or frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |
| cfg_err | output | 1 | Illegal data length captured |

## Verification
The new values of `sd` and `ws` are due on the clock edge that first sees `enable` high, and then every `2*HALF_DIV` edges. `sck` flips `HALF_DIV` edges into each period. The underrun flag and the emptying of the holding slot land on the frame-start edge itself, and `s_ready` falls on the edge that accepts a pair. `cfg_err` follows the configuration captured on each edge where `enable` is low. The bench's reference model advances on the same rising edges from the port values it sees. Every output is compared with the model's prediction at the following falling edge, so each result is checked in the cycle it is due and no later.

// File: rtl/audfmt_pkg.sv
package audfmt_pkg;

  localparam int unsigned MAX_W = 32;
  localparam int unsigned POS_W = $clog2(2 * MAX_W + 1);

  typedef logic [MAX_W-1:0] word_t;
  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'b00,
    STD_LEFT    = 2'b01,
    STD_RIGHT   = 2'b10,
    STD_PCM     = 2'b11
  } std_e;

  typedef struct packed {
    std_e       std;
    logic       sync_long;
    logic       cpol;
    logic [1:0] dlen;
    logic       slot32;
  } cfg_t;

  // Number of data bits carried per word; the illegal code falls back to 16.
  function automatic pos_t data_bits(logic [1:0] dlen);
    case (dlen)
      2'b01:   return POS_W'(24);
      2'b10:   return POS_W'(32);
      default: return POS_W'(16);
    endcase
  endfunction

  // Slot width: wide data always forces a 32-bit slot.
  function automatic pos_t slot_bits(logic [1:0] dlen, logic slot32);
    if (dlen == 2'b01 || dlen == 2'b10 || slot32) return POS_W'(32);
    return POS_W'(16);
  endfunction

  // Undelayed line value at frame position b.
  function automatic logic slot_bit(std_e std, word_t wl, word_t wr,
                                    pos_t b, pos_t n, pos_t l);
    word_t w;
    pos_t  i;
    pos_t  idx;
    logic  hit;
    w = wl;
    i = b;
    if (std != STD_PCM && b >= l) begin
      w = wr;
      i = b - l;
    end
    if (std == STD_RIGHT) begin
      hit = (i >= l - n);
      idx = l - POS_W'(1) - i;
    end else begin
      hit = (i < n);
      idx = n - POS_W'(1) - i;
    end
    return hit & (|(w & (word_t'(1) << idx)));
  endfunction

endpackage

// File: rtl/audfmt_cfg.sv
module audfmt_cfg
  import audfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  cfg_t cfg_in,
  output cfg_t cfg_q,
  output logic cfg_err
);

  // Shadow copy follows the inputs only while the serializer is stopped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!enable) begin
      cfg_q <= cfg_in;
    end
  end

  assign cfg_err = (cfg_q.dlen == 2'b11);

endmodule

// File: rtl/audfmt_clkgen.sv
module audfmt_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic start,
  output logic bit_adv,
  output logic phase
);

  localparam int unsigned CW = $clog2(HALF_DIV + 1);

  logic          started;
  logic [CW-1:0] cnt;
  logic          half_end;

  assign half_end = (cnt == CW'(HALF_DIV - 1));
  assign start    = enable & ~started;
  assign bit_adv  = enable & started & phase & half_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      started <= 1'b0;
      cnt     <= '0;
      phase   <= 1'b0;
    end else if (!started) begin
      started <= 1'b1;
      cnt     <= '0;
      phase   <= 1'b0;
    end else if (half_end) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/audfmt_hold.sv
module audfmt_hold
  import audfmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  output logic  s_ready,
  input  word_t s_left,
  input  word_t s_right,
  input  logic  take,
  output logic  hold_v,
  output word_t hold_l,
  output word_t hold_r
);

  assign s_ready = ~hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (s_valid && !hold_v) begin
      hold_v <= 1'b1;
      hold_l <= s_left;
      hold_r <= s_right;
    end else if (take) begin
      hold_v <= 1'b0;
    end
  end

endmodule

// File: rtl/audfmt_frame.sv
module audfmt_frame
  import audfmt_pkg::*;
#(
  parameter int unsigned LONG_SYNC = 13
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  start,
  input  logic  bit_adv,
  input  cfg_t  cfg,
  input  logic  hold_v,
  input  word_t hold_l,
  input  word_t hold_r,
  input  logic  underrun_clr,
  output logic  take,
  output logic  sd,
  output logic  ws,
  output logic  underrun
);

  pos_t  pos_q, pos_n, n_bits, l_bits, f_bits;
  word_t cur_l, cur_r, nxt_l, nxt_r;
  logic  lag_q, raw, ws_n, frame_end, load, adv, is_pcm;

  assign is_pcm    = (cfg.std == STD_PCM);
  assign n_bits    = data_bits(cfg.dlen);
  assign l_bits    = slot_bits(cfg.dlen, cfg.slot32);
  assign f_bits    = is_pcm ? l_bits : pos_t'(l_bits << 1);
  assign frame_end = (pos_q == f_bits - POS_W'(1));
  assign adv       = start | bit_adv;
  assign load      = start | (bit_adv & frame_end);
  assign take      = load & hold_v;
  assign pos_n     = (start || frame_end) ? '0 : pos_q + POS_W'(1);

  always_comb begin
    nxt_l = cur_l;
    nxt_r = cur_r;
    if (load) begin
      nxt_l = hold_v ? hold_l : '0;
      nxt_r = hold_v ? hold_r : '0;
    end
  end

  assign raw = slot_bit(cfg.std, nxt_l, nxt_r, pos_n, n_bits, l_bits);

  always_comb begin
    if (is_pcm) begin
      ws_n = cfg.sync_long ? (pos_n < POS_W'(LONG_SYNC))
                           : (pos_n == l_bits - POS_W'(1));
    end else begin
      ws_n = (pos_n >= l_bits);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      pos_q <= '0;
      cur_l <= '0;
      cur_r <= '0;
      lag_q <= 1'b0;
      sd    <= 1'b0;
      ws    <= 1'b0;
    end else if (adv) begin
      pos_q <= pos_n;
      cur_l <= nxt_l;
      cur_r <= nxt_r;
      lag_q <= raw;
      sd    <= (cfg.std == STD_PHILIPS) ? lag_q : raw;
      ws    <= ws_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underrun <= 1'b0;
    end else if (load && !hold_v) begin
      underrun <= 1'b1;
    end else if (underrun_clr) begin
      underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/audfmt_tx.sv
module audfmt_tx
  import audfmt_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned LONG_SYNC = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  cfg_std,
  input  logic        cfg_sync_long,
  input  logic        cfg_cpol,
  input  logic [1:0]  cfg_dlen,
  input  logic        cfg_slot32,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_left,
  input  logic [31:0] s_right,
  input  logic        underrun_clr,
  output logic        sck,
  output logic        ws,
  output logic        sd,
  output logic        underrun,
  output logic        cfg_err
);

  cfg_t  cfg_in, cfg_q;
  logic  start_p, bit_adv, phase, take, hold_v;
  word_t hold_l, hold_r;

  assign cfg_in.std       = std_e'(cfg_std);
  assign cfg_in.sync_long = cfg_sync_long;
  assign cfg_in.cpol      = cfg_cpol;
  assign cfg_in.dlen      = cfg_dlen;
  assign cfg_in.slot32    = cfg_slot32;

  audfmt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .cfg_err(cfg_err)
  );

  audfmt_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start(start_p), .bit_adv(bit_adv), .phase(phase)
  );

  audfmt_hold u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .take(take),
    .hold_v(hold_v), .hold_l(hold_l), .hold_r(hold_r)
  );

  audfmt_frame #(.LONG_SYNC(LONG_SYNC)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start_p),
    .bit_adv(bit_adv), .cfg(cfg_q), .hold_v(hold_v), .hold_l(hold_l),
    .hold_r(hold_r), .underrun_clr(underrun_clr), .take(take),
    .sd(sd), .ws(ws), .underrun(underrun)
  );

  assign sck = cfg_q.cpol ^ phase;

endmodule

// File: rtl/audfmt_tx_chk.sv
module audfmt_tx_chk
  import audfmt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cfg_cpol,
  input logic s_valid,
  input logic s_ready,
  input logic underrun,
  input logic underrun_clr,
  input logic sd,
  input logic ws,
  input logic sck,
  input logic start_p,
  input logic bit_adv,
  input cfg_t cfg_q
);

  a_r1_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sck == $past(cfg_cpol)));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !start_p && !bit_adv) |=> ($stable(sd) && $stable(ws)));

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(cfg_q));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sd && !ws));

endmodule

bind audfmt_tx audfmt_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_cpol(cfg_cpol),
  .s_valid(s_valid), .s_ready(s_ready), .underrun(underrun),
  .underrun_clr(underrun_clr), .sd(sd), .ws(ws), .sck(sck),
  .start_p(start_p), .bit_adv(bit_adv), .cfg_q(cfg_q)
);

// File: tb/audfmt_tx_tb_top.sv
module audfmt_tx_tb_top;

  localparam int H = 2;

  logic clk = 0, rst_n = 0, enable = 0;
  logic [1:0] cfg_std = 0, cfg_dlen = 0;
  logic cfg_sync_long = 0, cfg_cpol = 0, cfg_slot32 = 0;
  logic s_valid = 0, underrun_clr = 0;
  logic [31:0] s_left = 0, s_right = 0;
  wire s_ready, sck, ws, sd, underrun, cfg_err;

  always #10 clk = ~clk;

  audfmt_tx #(.HALF_DIV(H), .LONG_SYNC(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_std(cfg_std),
    .cfg_sync_long(cfg_sync_long), .cfg_cpol(cfg_cpol), .cfg_dlen(cfg_dlen),
    .cfg_slot32(cfg_slot32), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .underrun_clr(underrun_clr),
    .sck(sck), .ws(ws), .sd(sd), .underrun(underrun), .cfg_err(cfg_err)
  );

  int errors = 0, checks = 0;
  string tag = "R13";
  bit done = 0, feed_en = 0;
  logic [31:0] rng = 32'h1234_5678;

  // Reference model state
  int m_std, m_long, m_cpol, m_dlen, m_slot, m_t;
  bit m_run, m_bufv, m_under, m_acc;
  logic [31:0] m_bufl, m_bufr, m_curl, m_curr, m_prvl, m_prvr;

  task automatic chk(string t, logic a, logic e, string what);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", t, what, a, e, $time);
    end
  endtask

  function automatic int nbits(int d);
    return (d == 1) ? 24 : (d == 2) ? 32 : 16;
  endfunction
  function automatic int lbits(int d, int s);
    return (d == 1 || d == 2 || s != 0) ? 32 : 16;
  endfunction
  function automatic int fbits(int st, int d, int s);
    return (st == 3) ? lbits(d, s) : 2 * lbits(d, s);
  endfunction
  function automatic bit bv(int st, logic [31:0] wl, logic [31:0] wr,
                            int b, int n, int l);
    logic [31:0] w;
    int i;
    if (st != 3 && b >= l) begin w = wr; i = b - l; end
    else begin w = wl; i = b; end
    if (st == 2) return (i >= l - n) ? w[l-1-i] : 1'b0;
    return (i < n) ? w[n-1-i] : 1'b0;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_std = 0; m_long = 0; m_cpol = 0; m_dlen = 0; m_slot = 0; m_t = 0;
      m_run = 0; m_bufv = 0; m_under = 0; m_acc = 0;
      m_curl = 0; m_curr = 0; m_prvl = 0; m_prvr = 0; m_bufl = 0; m_bufr = 0;
    end else begin
      bit ld, was_v;
      ld = 0;
      was_v = m_bufv;
      m_acc = s_valid && !m_bufv;
      if (!enable) begin
        m_std = cfg_std; m_long = cfg_sync_long; m_cpol = cfg_cpol;
        m_dlen = cfg_dlen; m_slot = cfg_slot32; m_run = 0;
      end else if (!m_run) begin
        m_run = 1; m_t = 0; ld = 1;
      end else begin
        m_t++;
        if (m_t % (2 * H * fbits(m_std, m_dlen, m_slot)) == 0) ld = 1;
      end
      if (ld) begin
        m_prvl = (m_t == 0) ? 32'h0 : m_curl;
        m_prvr = (m_t == 0) ? 32'h0 : m_curr;
        m_curl = was_v ? m_bufl : 32'h0;
        m_curr = was_v ? m_bufr : 32'h0;
        if (was_v) m_bufv = 0;
      end
      if (ld && !was_v) m_under = 1;
      else if (underrun_clr) m_under = 0;
      if (m_acc) begin m_bufv = 1; m_bufl = s_left; m_bufr = s_right; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit esd, ews, esck;
      string t;
      if (m_run) begin
        int n, l, f, p, b;
        n = nbits(m_dlen); l = lbits(m_dlen, m_slot);
        f = fbits(m_std, m_dlen, m_slot);
        p = m_t / (2 * H); b = p % f;
        esck = m_cpol[0] ^ ((m_t % (2 * H)) >= H);
        if (m_std == 0)
          esd = (b == 0) ? bv(0, m_prvl, m_prvr, f - 1, n, l)
                         : bv(0, m_curl, m_curr, b - 1, n, l);
        else
          esd = bv(m_std, m_curl, m_curr, b, n, l);
        if (m_std == 3) ews = m_long ? (b < 13) : (b == l - 1);
        else ews = (b >= l);
        t = tag;
      end else begin
        esck = m_cpol[0]; esd = 0; ews = 0; t = "R13";
      end
      chk("R2", sck, esck, "sck");
      chk(t, sd, esd, "sd");
      chk(t, ws, ews, "ws");
      chk("R1", s_ready, !m_bufv, "s_ready");
      chk("R12", underrun, m_under, "underrun");
      chk("R11", cfg_err, m_dlen == 3, "cfg_err");
      if (m_acc) begin
        rng = nxt(rng); s_left = rng;
        rng = nxt(rng); s_right = rng;
      end
      s_valid = feed_en;
    end
  end

  task automatic run(int st, int lg, int cp, int dl, int sl, int frames,
                     string tg, bit feed, bit midchg, bit clrp);
    int len;
    @(negedge clk);
    enable = 0;
    cfg_std = st[1:0]; cfg_sync_long = lg[0]; cfg_cpol = cp[0];
    cfg_dlen = dl[1:0]; cfg_slot32 = sl[0];
    feed_en = feed;
    repeat (4) @(negedge clk);
    tag = tg;
    enable = 1;
    len = frames * 2 * H * fbits(st, dl, sl);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (midchg && c == len / 3) begin
        cfg_std = ~cfg_std; cfg_cpol = ~cfg_cpol;
        cfg_dlen = cfg_dlen + 2'd1; cfg_slot32 = ~cfg_slot32;
        cfg_sync_long = ~cfg_sync_long;
      end
      underrun_clr = clrp && (c == len / 2 || c == len / 2 + 3);
    end
    @(negedge clk);
    underrun_clr = 0;
    enable = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R13", sd, 1'b0, "sd in reset");
    chk("R13", ws, 1'b0, "ws in reset");
    chk("R13", s_ready, 1'b1, "s_ready in reset");
    chk("R13", underrun, 1'b0, "underrun in reset");
    chk("R13", cfg_err, 1'b0, "cfg_err in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 0, 0, 0, 0, 3, "R4", 1, 0, 0);
    run(0, 0, 1, 1, 0, 3, "R4 R7 R8", 1, 0, 0);
    run(0, 0, 0, 2, 1, 2, "R4 R7", 1, 0, 0);
    run(1, 0, 0, 0, 1, 3, "R5 R8", 1, 0, 0);
    run(1, 1, 1, 1, 0, 2, "R5 R9", 1, 0, 0);
    run(2, 0, 0, 1, 1, 3, "R6 R7", 1, 0, 0);
    run(2, 0, 0, 0, 0, 2, "R6", 1, 0, 0);
    run(3, 0, 0, 0, 0, 4, "R9", 1, 0, 0);
    run(3, 1, 0, 2, 0, 3, "R10", 1, 0, 0);
    run(3, 1, 1, 0, 1, 3, "R10 R8", 1, 0, 0);
    run(0, 0, 0, 3, 1, 2, "R11", 1, 0, 0);
    run(2, 0, 1, 0, 1, 3, "R3", 1, 1, 0);
    run(1, 0, 0, 0, 0, 4, "R12", 0, 0, 1);
    run(0, 0, 0, 1, 0, 2, "R12 R1", 1, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule